// File: doc/BRIEF.md
# DMA Data Width Adaptation Unit

This stage sits in a DMA channel between the read side and the write side. Each beat read from the source has a width of a byte, a halfword or a word, and the stage turns it into beats of the configured destination width. A policy selector decides what happens when the two widths differ. Depending on the direction of the mismatch, it can zero-pad or truncate, sign-extend or keep the most significant part, or pack or unpack. Separate byte and halfword exchange options act on the source data before conversion and on the destination data after it.

Both sides are valid/ready streams. The stage has a registered output beat. It also has one 32-bit holding register, which gathers narrow beats when packing and holds a wide beat while it is split when unpacking. A flush input forces out a partly filled packed beat. Configuration is expected to change only while the stage is idle, with no beat pending and no partial pack.

Top module: `dma_width_adapter`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: When the source and destination size codes are equal (0 byte, 1 halfword, 2 word), the beat passes through unchanged apart from the selected exchanges, whatever the policy code.
- R3: With policy 0 and a narrower source, the source bits are right-aligned and the bits up to the destination width are zero.
- R4: With policy 0 and a wider source, the low-order destination-width bits of the source are kept.
- R5: With policy 1 and a narrower source, the value is right-aligned and sign-extended from the source's top bit to the destination width.
- R6: With policy 1 and a wider source, the most significant destination-width bits of the source are kept.
- R7: With policy 2 and a narrower source, source beats fill destination lanes from the least significant lane upward. One output beat appears only after the last lane is filled.
- R8: With policy 2 and a narrower source, a flush while lanes are partly filled emits the partial beat with the unfilled lanes zero. A flush with no lanes filled emits nothing.
- R9: With policy 2 and a wider source, each source beat yields width-ratio destination beats, lowest part first. in_ready stays low until the last part is emitted.
- R10: Source byte exchange (src_bswap) swaps the two bytes of each halfword, and only when the source size is word. Otherwise it has no effect.
- R11: Destination byte exchange (dst_bswap) swaps bytes within each halfword of a halfword or word destination and is ignored for a byte destination. Destination halfword exchange (dst_hswap) swaps the two halfwords of a word destination only. The byte exchange is applied first.
- R12: out_data bits above the destination width are zero. While out_valid is high and out_ready is low, out_valid and out_data hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_size | input | 2 | Source width: 0 byte, 1 halfword, 2 word (3 treated as word) |
| dst_size | input | 2 | Destination width, same coding |
| policy | input | 2 | 0 pad/truncate, 1 sign-extend/keep-high, 2 pack/unpack (3 acts as 0) |
| src_bswap | input | 1 | Source byte exchange enable |
| dst_bswap | input | 1 | Destination byte exchange enable |
| dst_hswap | input | 1 | Destination halfword exchange enable |
| in_valid | input | 1 | Source beat valid |
| in_ready | output | 1 | Source beat accepted this cycle when high with in_valid |
| in_data | input | 32 | Source beat, right-aligned |
| flush | input | 1 | Emit a partly filled packed beat |
| out_valid | output | 1 | Destination beat valid |
| out_ready | input | 1 | Destination side accepts the beat |
| out_data | output | 32 | Destination beat, right-aligned |

## Verification
The assertions check the stall behaviour on every cycle: a beat held under backpressure must not change. They also check that bits above the destination width stay clear, that the lane counter stays below the width ratio, that a non-final pack beat produces no output, and that an accepted unpack beat yields output on the next cycle.

The numerical results need the bench's scenarios. These are the padding and sign-extension values, which half is kept, lane order in pack and unpack, the zero fill on flush, and which exchange options are ignored for each width. In each scenario the bench compares the captured output beats against values it works out by hand.

// File: rtl/dma_width_adapter.sv
module dma_width_adapter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  src_size,
  input  logic [1:0]  dst_size,
  input  logic [1:0]  policy,
  input  logic        src_bswap,
  input  logic        dst_bswap,
  input  logic        dst_hswap,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic        flush,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data
);

  function automatic logic [31:0] lane_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    lane_mask = 32'h0000_00FF;
      2'd1:    lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] swap_bytes(input logic [31:0] v);
    swap_bytes = {v[23:16], v[31:24], v[7:0], v[15:8]};
  endfunction

  function automatic logic [31:0] dst_fix(input logic [31:0] v, input logic [1:0] sz,
                                          input logic bx, input logic hx);
    logic [31:0] t;
    t = v;
    if (bx && sz != 2'd0) t = swap_bytes(t);
    if (hx && sz == 2'd2) t = {t[15:0], t[31:16]};
    dst_fix = t & lane_mask(sz);
  endfunction

  logic [1:0]  ssz, dsz, diff, last_lane, cnt;
  logic        narrow, wide, pack_mode, unpack_mode, slot_free;
  logic        load, accept, sign_bit;
  logic [31:0] src_v, conv, acc, lane_wr, lane_rd, load_data;
  logic [5:0]  wr_sh, rd_sh, hi_sh;

  assign ssz       = (src_size == 2'd3) ? 2'd2 : src_size;
  assign dsz       = (dst_size == 2'd3) ? 2'd2 : dst_size;
  assign src_v     = ((ssz == 2'd2 && src_bswap) ? swap_bytes(in_data) : in_data) & lane_mask(ssz);
  assign narrow    = ssz < dsz;
  assign wide      = ssz > dsz;
  assign diff      = narrow ? dsz - ssz : ssz - dsz;
  assign last_lane = (diff == 2'd2) ? 2'd3 : diff;
  assign pack_mode   = (policy == 2'd2) && narrow;
  assign unpack_mode = (policy == 2'd2) && wide;
  assign slot_free = !out_valid || out_ready;
  assign accept    = in_valid && in_ready;

  assign wr_sh   = {1'b0, cnt, 3'b000} << ssz;
  assign rd_sh   = {1'b0, cnt, 3'b000} << dsz;
  assign hi_sh   = (6'd8 << ssz) - (6'd8 << dsz);
  assign lane_wr = acc | (src_v << wr_sh);
  assign lane_rd = (acc >> rd_sh) & lane_mask(dsz);

  always_comb begin
    case (ssz)
      2'd0:    sign_bit = src_v[7];
      2'd1:    sign_bit = src_v[15];
      default: sign_bit = src_v[31];
    endcase
    if (narrow)
      conv = (policy == 2'd1 && sign_bit) ? (src_v | (lane_mask(dsz) & ~lane_mask(ssz))) : src_v;
    else if (wide)
      conv = (policy == 2'd1) ? ((src_v >> hi_sh) & lane_mask(dsz)) : (src_v & lane_mask(dsz));
    else
      conv = src_v;
  end

  always_comb begin
    load      = 1'b0;
    load_data = '0;
    if (pack_mode) begin
      in_ready = slot_free && !(flush && cnt != 2'd0);
      if (slot_free && flush && cnt != 2'd0) begin
        load      = 1'b1;
        load_data = dst_fix(acc, dsz, dst_bswap, dst_hswap);
      end else if (in_valid && in_ready && cnt == last_lane) begin
        load      = 1'b1;
        load_data = dst_fix(lane_wr, dsz, dst_bswap, dst_hswap);
      end
    end else if (unpack_mode) begin
      in_ready = slot_free && cnt == 2'd0;
      if (slot_free && cnt != 2'd0) begin
        load      = 1'b1;
        load_data = dst_fix(lane_rd, dsz, dst_bswap, dst_hswap);
      end else if (in_valid && in_ready) begin
        load      = 1'b1;
        load_data = dst_fix(src_v & lane_mask(dsz), dsz, dst_bswap, dst_hswap);
      end
    end else begin
      in_ready  = slot_free;
      load      = in_valid && slot_free;
      load_data = dst_fix(conv, dsz, dst_bswap, dst_hswap);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      acc       <= '0;
      cnt       <= '0;
    end else begin
      if (load) begin
        out_valid <= 1'b1;
        out_data  <= load_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (pack_mode) begin
        if (slot_free && flush && cnt != 2'd0) begin
          acc <= '0;
          cnt <= '0;
        end else if (accept) begin
          if (cnt == last_lane) begin
            acc <= '0;
            cnt <= '0;
          end else begin
            acc <= lane_wr;
            cnt <= cnt + 2'd1;
          end
        end
      end else if (unpack_mode) begin
        if (accept) begin
          acc <= src_v;
          cnt <= 2'd1;
        end else if (slot_free && cnt != 2'd0) begin
          cnt <= (cnt == last_lane) ? 2'd0 : cnt + 2'd1;
        end
      end else begin
        acc <= '0;
        cnt <= '0;
      end
    end
  end

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_upper_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data & ~lane_mask(dsz)) == 32'h0);

  assert_lane_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pack_mode || unpack_mode) |-> cnt <= last_lane);

  assert_pack_no_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pack_mode && accept && cnt != last_lane |=> !out_valid);

  assert_unpack_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unpack_mode && accept |=> out_valid);

endmodule

// File: tb/tb_dma_width_adapter.sv
module tb_dma_width_adapter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] src_size = 2'd2, dst_size = 2'd2, policy = 2'd0;
  logic src_bswap = 1'b0, dst_bswap = 1'b0, dst_hswap = 1'b0;
  logic in_valid = 1'b0, flush = 1'b0, out_ready = 1'b1;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid;
  logic [31:0] out_data;

  always #2 clk = ~clk;

  dma_width_adapter dut (
    .clk(clk), .rst_n(rst_n), .src_size(src_size), .dst_size(dst_size), .policy(policy),
    .src_bswap(src_bswap), .dst_bswap(dst_bswap), .dst_hswap(dst_hswap),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .flush(flush),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  int total = 0, fails = 0, ncap = 0;
  logic [31:0] cap [64];

  always @(negedge clk)
    if (rst_n && out_valid && out_ready) begin
      cap[ncap % 64] = out_data;
      ncap = ncap + 1;
    end

  // {src_size, dst_size, policy, src_bswap, dst_bswap, dst_hswap, din, dout, req}
  localparam int NV = 21;
  localparam logic [76:0] VEC [NV] = '{
    {2'd2,2'd2,2'd0,1'b0,1'b0,1'b0,32'h12345678,32'h12345678,4'd2},  // R2
    {2'd2,2'd2,2'd0,1'b1,1'b0,1'b0,32'h12345678,32'h34127856,4'd10}, // R10
    {2'd2,2'd2,2'd0,1'b0,1'b1,1'b0,32'h12345678,32'h34127856,4'd11}, // R11
    {2'd2,2'd2,2'd0,1'b0,1'b0,1'b1,32'h12345678,32'h56781234,4'd11}, // R11
    {2'd2,2'd2,2'd0,1'b1,1'b0,1'b1,32'h12345678,32'h78563412,4'd2},  // R2
    {2'd0,2'd2,2'd0,1'b0,1'b0,1'b0,32'hAABBCCF5,32'h000000F5,4'd3},  // R3
    {2'd0,2'd2,2'd1,1'b0,1'b0,1'b0,32'h000000F5,32'hFFFFFFF5,4'd5},  // R5
    {2'd0,2'd1,2'd1,1'b0,1'b0,1'b0,32'h00000075,32'h00000075,4'd5},  // R5
    {2'd1,2'd2,2'd1,1'b0,1'b0,1'b0,32'h00008001,32'hFFFF8001,4'd5},  // R5
    {2'd2,2'd0,2'd0,1'b0,1'b0,1'b0,32'h12345678,32'h00000078,4'd4},  // R4
    {2'd2,2'd1,2'd0,1'b0,1'b0,1'b0,32'h12345678,32'h00005678,4'd4},  // R4
    {2'd2,2'd0,2'd1,1'b0,1'b0,1'b0,32'h12345678,32'h00000012,4'd6},  // R6
    {2'd2,2'd1,2'd1,1'b0,1'b0,1'b0,32'h12345678,32'h00001234,4'd6},  // R6
    {2'd1,2'd0,2'd1,1'b0,1'b0,1'b0,32'h0000ABCD,32'h000000AB,4'd6},  // R6
    {2'd1,2'd1,2'd0,1'b1,1'b0,1'b0,32'hFFFF1234,32'h00001234,4'd12}, // R12, R10
    {2'd0,2'd0,2'd0,1'b0,1'b1,1'b0,32'h000000AB,32'h000000AB,4'd11}, // R11
    {2'd1,2'd1,2'd0,1'b0,1'b1,1'b0,32'h00001234,32'h00003412,4'd11}, // R11
    {2'd1,2'd1,2'd0,1'b0,1'b0,1'b1,32'h00001234,32'h00001234,4'd11}, // R11
    {2'd2,2'd1,2'd0,1'b0,1'b1,1'b0,32'h12345678,32'h00007856,4'd11}, // R11
    {2'd2,2'd2,2'd1,1'b0,1'b0,1'b0,32'h12345678,32'h12345678,4'd2},  // R2
    {2'd0,2'd1,2'd0,1'b1,1'b0,1'b0,32'h00000080,32'h00000080,4'd10}  // R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] s, input logic [1:0] d, input logic [1:0] p,
                     input logic sb, input logic db, input logic dh);
    @(posedge clk); #1;
    src_size = s; dst_size = d; policy = p;
    src_bswap = sb; dst_bswap = db; dst_hswap = dh;
  endtask

  task automatic push(input logic [31:0] d);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = d;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(posedge clk); #1;
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #200000;
    total++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    report();
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid", {31'b0, out_valid}, 32'h0);
    check("R1 in_ready", {31'b0, in_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      cfg(VEC[i][76:75], VEC[i][74:73], VEC[i][72:71], VEC[i][70], VEC[i][69], VEC[i][68]);
      base = ncap;
      push(VEC[i][67:36]);
      idle(3);
      check($sformatf("R%0d vector %0d count", VEC[i][3:0], i), ncap - base, 1);
      check($sformatf("R%0d vector %0d data", VEC[i][3:0], i), cap[base % 64], VEC[i][35:4]);
    end

    // R7 byte to word pack
    cfg(2'd0, 2'd2, 2'd2, 1'b0, 1'b0, 1'b0);
    base = ncap;
    push(32'h11); push(32'h22); push(32'h33);
    idle(2);
    check("R7 no early beat", ncap - base, 0);
    push(32'h44);
    idle(2);
    check("R7 pack count", ncap - base, 1);
    check("R7 pack byte lanes", cap[base % 64], 32'h44332211);

    // R7 halfword to word pack with halfword exchange (R11)
    cfg(2'd1, 2'd2, 2'd2, 1'b0, 1'b0, 1'b1);
    base = ncap;
    push(32'hAAAA); push(32'hBBBB);
    idle(2);
    check("R7 R11 pack swapped", cap[base % 64], 32'hAAAABBBB);

    // R8 flush
    cfg(2'd0, 2'd2, 2'd2, 1'b0, 1'b0, 1'b0);
    base = ncap;
    do_flush(); do_flush();
    idle(2);
    check("R8 empty flush", ncap - base, 0);
    push(32'h5A);
    idle(2);
    check("R8 partial held", ncap - base, 0);
    do_flush();
    idle(2);
    check("R8 flush count", ncap - base, 1);
    check("R8 flush data", cap[base % 64], 32'h0000005A);
    push(32'h01); push(32'h02); push(32'h03); push(32'h04);
    idle(2);
    check("R8 R7 after flush", cap[(base + 1) % 64], 32'h04030201);

    // R9 word to byte unpack
    cfg(2'd2, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0);
    base = ncap;
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = 32'h12345678;
    @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    check("R9 busy in_ready", {31'b0, in_ready}, 32'h0);
    idle(6);
    check("R9 unpack count", ncap - base, 4);
    check("R9 lane0", cap[base % 64], 32'h78);
    check("R9 lane1", cap[(base + 1) % 64], 32'h56);
    check("R9 lane2", cap[(base + 2) % 64], 32'h34);
    check("R9 lane3", cap[(base + 3) % 64], 32'h12);

    // R9 word to halfword unpack with source byte exchange (R10)
    cfg(2'd2, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0);
    base = ncap;
    push(32'h12345678);
    idle(4);
    check("R9 R10 half count", ncap - base, 2);
    check("R9 R10 half0", cap[base % 64], 32'h7856);
    check("R9 R10 half1", cap[(base + 1) % 64], 32'h3412);

    // R12 backpressure
    cfg(2'd2, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0);
    out_ready = 1'b0;
    base = ncap;
    push(32'hCAFEF00D);
    idle(3);
    @(negedge clk);
    check("R12 held valid", {31'b0, out_valid}, 32'h1);
    check("R12 held data", out_data, 32'hCAFEF00D);
    check("R12 stalled in_ready", {31'b0, in_ready}, 32'h0);
    @(posedge clk); #1;
    out_ready = 1'b1;
    idle(2);
    check("R12 drained", ncap - base, 1);
    check("R12 drained data", cap[base % 64], 32'hCAFEF00D);

    report();
  end
endmodule